// File: doc/BRIEF.md
# Partial-Width Aliased Register File

This block holds sixteen 64-bit general-purpose registers. Every register can be reached through narrower views: the whole 64 bits, the low 32, the low 16 or the low 8. The first four registers also offer a second byte view on bits 15..8, kept for older code. There are two combinational read ports and one write port. Each port gives a register index and a two-bit size code, and one shared mode input settles what a byte access to indices 4..7 means.

Reads return the selected slice zero-extended to 64 bits. Writes follow a width rule:
- A 64-bit write replaces the register.
- A 32-bit write loads the low half and clears the upper half.
- A 16-bit or 8-bit write merges into the register and keeps every other bit.

An output flags a cycle in which a high-byte view and one of the newer low-byte views are both in use. The write in that cycle still goes ahead.

Top module: `gpr_alias_file`

## Requirements
- R1: A synchronous active-high reset clears all sixteen registers to zero; every read after the reset edge returns zero.
- R2: Size codes are 2'b00 = 8-bit, 2'b01 = 16-bit, 2'b10 = 32-bit and 2'b11 = 64-bit. A read returns bits 7..0, 15..0, 31..0 or 63..0 of the selected register, zero-extended to 64 bits. For sizes other than 8-bit, the mode input has no effect.
- R3: A 16-bit write loads bits 15..0 of the register. An 8-bit low-byte write loads bits 7..0. In both cases all other bits are kept.
- R4: A 32-bit write loads bits 31..0 from the write data and forces bits 63..32 to zero.
- R5: A 64-bit write replaces all 64 bits.
- R6: With the mode input at 0, an 8-bit access to index 4, 5, 6 or 7 uses bits 15..8 of register index-4. A read returns those bits in bits 7..0 of the result. A write takes write-data bits 7..0 into bits 15..8 and changes nothing else.
- R7: With the mode input at 1, an 8-bit access to index 4..7 uses bits 7..0 of that same register. An 8-bit access to index 8..15 always uses bits 7..0 of that register.
- R8: The illegal-combination output is high, in the same cycle, when one port uses a high-byte view (R6) and another port makes an 8-bit access to bits 7..0 of a register with index 4..15. Both read ports always count; the write port counts only while write enable is high. The write is still performed.
- R9: When a read and a write address the same register in one cycle, the read returns the value from before the write. The new value appears after the clock edge.
- R10: With write enable low, no register changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | Selects how byte accesses to indices 4..7 are resolved (0: high bytes of registers 0..3, 1: low bytes of registers 4..7) |
| rd0_idx | input | 4 | Read port 0 register index |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_data | output | 64 | Read port 0 data, zero-extended |
| rd1_idx | input | 4 | Read port 1 register index |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_data | output | 64 | Read port 1 data, zero-extended |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 2 | Write size code |
| wr_data | input | 64 | Write data, right-aligned |
| illegal_combo | output | 1 | High-byte and new low-byte views used together this cycle |

## Verification
The assertions assume that reset is asserted in the first cycle, so the storage is known before any width rule is checked. They also assume that the write inputs are stable around each rising edge, so that the $past index names the register actually written.

The bench holds reset from time zero. It changes every input only on the falling clock edge, and it samples outputs a quarter period later, away from the active edge. While the mode input is 1, the bench never forms a high-byte view, which matches the assumption that no illegal combination exists in that mode.

// File: rtl/gpr_alias_pkg.sv
package gpr_alias_pkg;

  // Access width codes shared by all ports.
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } acc_size_e;

  // Decoded view of one port access.
  typedef struct packed {
    acc_size_e size;
    logic      hi_byte;   // bits 15..8 of a legacy register
    logic      new_low;   // byte view of index 4..15 low bits
  } view_kind_t;

endpackage

// File: rtl/gpr_view_decode.sv
module gpr_view_decode
  import gpr_alias_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int LEGACY_HI = 4,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       size,
  input  logic             ext_mode,
  output logic [IDX_W-1:0] phys,
  output view_kind_t       kind
);

  localparam logic [IDX_W-1:0] ALIAS_LO = IDX_W'(LEGACY_HI);
  localparam logic [IDX_W-1:0] ALIAS_HI = IDX_W'(2 * LEGACY_HI);

  logic is_byte;
  logic in_alias;
  logic hi_sel;

  always_comb begin
    is_byte  = (acc_size_e'(size) == SZ_BYTE);
    in_alias = (idx >= ALIAS_LO) && (idx < ALIAS_HI);
    hi_sel   = is_byte && in_alias && !ext_mode;
    phys     = hi_sel ? (idx - ALIAS_LO) : idx;
    kind.size    = acc_size_e'(size);
    kind.hi_byte = hi_sel;
    kind.new_low = is_byte && !hi_sel && (idx >= ALIAS_LO);
  end

endmodule

// File: rtl/gpr_read_slice.sv
module gpr_read_slice
  import gpr_alias_pkg::*;
#(
  parameter int XLEN  = 64,
  localparam int HALF = XLEN / 2
) (
  input  logic [XLEN-1:0] value,
  input  view_kind_t      kind,
  output logic [XLEN-1:0] data
);

  always_comb begin
    data = '0;
    unique case (kind.size)
      SZ_BYTE:  data[7:0]      = kind.hi_byte ? value[15:8] : value[7:0];
      SZ_HALF:  data[15:0]     = value[15:0];
      SZ_WORD:  data[HALF-1:0] = value[HALF-1:0];
      default:  data           = value;
    endcase
  end

endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge
  import gpr_alias_pkg::*;
#(
  parameter int XLEN  = 64,
  localparam int HALF = XLEN / 2
) (
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] wdata,
  input  view_kind_t      kind,
  output logic [XLEN-1:0] new_val
);

  always_comb begin
    new_val = old_val;
    unique case (kind.size)
      SZ_BYTE: begin
        if (kind.hi_byte) new_val[15:8] = wdata[7:0];
        else              new_val[7:0]  = wdata[7:0];
      end
      SZ_HALF: new_val[15:0] = wdata[15:0];
      SZ_WORD: new_val = {{(XLEN-HALF){1'b0}}, wdata[HALF-1:0]};
      default: new_val = wdata;
    endcase
  end

endmodule

// File: rtl/gpr_alias_file.sv
module gpr_alias_file
  import gpr_alias_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int XLEN      = 64,
  parameter int LEGACY_HI = 4,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int HALF     = XLEN / 2,
  localparam int NRD      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_mode,
  input  logic [IDX_W-1:0] rd0_idx,
  input  logic [1:0]       rd0_size,
  output logic [XLEN-1:0]  rd0_data,
  input  logic [IDX_W-1:0] rd1_idx,
  input  logic [1:0]       rd1_size,
  output logic [XLEN-1:0]  rd1_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_size,
  input  logic [XLEN-1:0]  wr_data,
  output logic             illegal_combo
);

  logic [XLEN-1:0] gpr_q [NUM_REGS];

  // Read ports
  logic [IDX_W-1:0] rd_idx_a  [NRD];
  logic [1:0]       rd_size_a [NRD];
  logic [IDX_W-1:0] rd_phys   [NRD];
  view_kind_t       rd_kind   [NRD];
  logic [XLEN-1:0]  rd_data_a [NRD];

  assign rd_idx_a[0]  = rd0_idx;
  assign rd_idx_a[1]  = rd1_idx;
  assign rd_size_a[0] = rd0_size;
  assign rd_size_a[1] = rd1_size;
  assign rd0_data     = rd_data_a[0];
  assign rd1_data     = rd_data_a[1];

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    gpr_view_decode #(.NUM_REGS(NUM_REGS), .LEGACY_HI(LEGACY_HI)) i_dec (
      .idx(rd_idx_a[p]), .size(rd_size_a[p]), .ext_mode(ext_mode),
      .phys(rd_phys[p]), .kind(rd_kind[p])
    );
    gpr_read_slice #(.XLEN(XLEN)) i_slice (
      .value(gpr_q[rd_phys[p]]), .kind(rd_kind[p]), .data(rd_data_a[p])
    );
  end

  // Write port
  logic [IDX_W-1:0] wr_phys;
  view_kind_t       wr_kind;
  logic [XLEN-1:0]  wr_merged;

  gpr_view_decode #(.NUM_REGS(NUM_REGS), .LEGACY_HI(LEGACY_HI)) i_wr_dec (
    .idx(wr_idx), .size(wr_size), .ext_mode(ext_mode),
    .phys(wr_phys), .kind(wr_kind)
  );

  gpr_write_merge #(.XLEN(XLEN)) i_merge (
    .old_val(gpr_q[wr_phys]), .wdata(wr_data), .kind(wr_kind), .new_val(wr_merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) gpr_q[r] <= '0;
    end else if (wr_en) begin
      gpr_q[wr_phys] <= wr_merged;
    end
  end

  // Mixed legacy/new byte views
  logic any_hi;
  logic any_new;

  always_comb begin
    any_hi  = (wr_en && wr_kind.hi_byte);
    any_new = (wr_en && wr_kind.new_low);
    for (int p = 0; p < NRD; p++) begin
      any_hi  = any_hi  | rd_kind[p].hi_byte;
      any_new = any_new | rd_kind[p].new_low;
    end
    illegal_combo = any_hi && any_new;
  end

  // Checks next to the storage they guard
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (rd0_data == '0 && rd1_data == '0));

  assert_narrow_keeps_upper_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_kind.size == SZ_HALF || (wr_kind.size == SZ_BYTE && !wr_kind.hi_byte)))
    |=> (gpr_q[$past(wr_phys)][XLEN-1:16] == $past(gpr_q[wr_phys][XLEN-1:16])));

  assert_word_clears_upper_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_kind.size == SZ_WORD)
    |=> (gpr_q[$past(wr_phys)][XLEN-1:HALF] == '0));

  assert_high_byte_keeps_rest_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_kind.hi_byte)
    |=> (gpr_q[$past(wr_phys)][7:0] == $past(gpr_q[wr_phys][7:0]) &&
         gpr_q[$past(wr_phys)][XLEN-1:16] == $past(gpr_q[wr_phys][XLEN-1:16])));

  assert_ext_mode_no_illegal_R8: assert property (@(posedge clk) disable iff (rst)
    ext_mode |-> !illegal_combo);

endmodule

// File: tb/test_gpr_alias_file.sv
`timescale 1ns/1ps
module test_gpr_alias_file;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_mode = 1'b0;
  logic [3:0]  rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
  logic [1:0]  rd0_size = 2'b11, rd1_size = 2'b11, wr_size = 2'b11;
  logic [63:0] rd0_data, rd1_data, wr_data = '0;
  logic        wr_en = 1'b0;
  logic        illegal_combo;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  gpr_alias_file i_gpr_alias_file (
    .clk(clk), .rst(rst), .ext_mode(ext_mode),
    .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data),
    .illegal_combo(illegal_combo)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {wr_en, wr_idx, wr_size, ext, wr_data, rd_idx, rd_size, expected}
  localparam int NV = 15;
  localparam logic [141:0] VEC [NV] = '{
    {1'b1, 4'd2,  2'b11, 1'b0, 64'h1122_3344_5566_7788, 4'd2,  2'b11, 64'h1122_3344_5566_7788},
    {1'b1, 4'd2,  2'b00, 1'b0, 64'hFFFF_FFFF_FFFF_FFAB, 4'd2,  2'b11, 64'h1122_3344_5566_77AB},
    {1'b1, 4'd2,  2'b01, 1'b0, 64'h0000_0000_0000_CDEF, 4'd2,  2'b11, 64'h1122_3344_5566_CDEF},
    {1'b1, 4'd6,  2'b00, 1'b0, 64'h0000_0000_0000_005A, 4'd2,  2'b11, 64'h1122_3344_5566_5AEF},
    {1'b0, 4'd0,  2'b00, 1'b0, 64'h0,                   4'd6,  2'b00, 64'h0000_0000_0000_005A},
    {1'b1, 4'd2,  2'b10, 1'b0, 64'hAAAA_BBBB_CCCC_DDDD, 4'd2,  2'b11, 64'h0000_0000_CCCC_DDDD},
    {1'b0, 4'd0,  2'b00, 1'b0, 64'h0,                   4'd2,  2'b01, 64'h0000_0000_0000_DDDD},
    {1'b0, 4'd0,  2'b00, 1'b0, 64'h0,                   4'd2,  2'b10, 64'h0000_0000_CCCC_DDDD},
    {1'b1, 4'd6,  2'b00, 1'b1, 64'h0000_0000_0000_0077, 4'd6,  2'b11, 64'h0000_0000_0000_0077},
    {1'b0, 4'd0,  2'b00, 1'b1, 64'h0,                   4'd6,  2'b00, 64'h0000_0000_0000_0077},
    {1'b1, 4'd13, 2'b11, 1'b0, 64'hFEDC_BA98_7654_3210, 4'd13, 2'b00, 64'h0000_0000_0000_0010},
    {1'b1, 4'd13, 2'b00, 1'b0, 64'h0000_0000_0000_0099, 4'd13, 2'b11, 64'hFEDC_BA98_7654_3299},
    {1'b0, 4'd13, 2'b11, 1'b0, 64'h0,                   4'd13, 2'b11, 64'hFEDC_BA98_7654_3299},
    {1'b1, 4'd6,  2'b01, 1'b0, 64'h0000_0000_0000_1234, 4'd6,  2'b11, 64'h0000_0000_0000_1234},
    {1'b0, 4'd0,  2'b00, 1'b0, 64'h0,                   4'd6,  2'b00, 64'h0000_0000_0000_00DD}
  };

  function automatic string vec_tag(input int n);
    case (n)
      0:       return "R5 full write";
      1, 2:    return "R3 narrow merge";
      3, 4:    return "R6 high byte";
      5:       return "R4 word clears upper";
      6, 7:    return "R2 read slice";
      8, 9:    return "R7 ext low byte";
      10:      return "R7 index 13 byte";
      11:      return "R3 byte merge";
      12:      return "R10 write disabled";
      13:      return "R2 size ignores mode";
      default: return "R6 high byte read";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: every register reads zero after reset
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      rd0_idx = 4'(r); rd0_size = 2'b11;
      #5 check($sformatf("R1 reset reg %0d", r), rd0_data, 64'h0);
    end

    for (int n = 0; n < NV; n++) begin
      @(negedge clk);
      wr_en    = VEC[n][141];
      wr_idx   = VEC[n][140:137];
      wr_size  = VEC[n][136:135];
      ext_mode = VEC[n][134];
      wr_data  = VEC[n][133:70];
      rd0_idx  = VEC[n][69:66];
      rd0_size = VEC[n][65:64];
      @(posedge clk);
      #5 check($sformatf("%s vec %0d", vec_tag(n), n), rd0_data, VEC[n][63:0]);
    end

    // R9: same-cycle read sees old value, new after edge
    @(negedge clk);
    ext_mode = 1'b0;
    wr_en = 1'b1; wr_idx = 4'd13; wr_size = 2'b11; wr_data = 64'h0123_4567_89AB_CDEF;
    rd0_idx = 4'd13; rd0_size = 2'b11;
    #5 check("R9 pre-write read", rd0_data, 64'hFEDC_BA98_7654_3299);
    @(posedge clk);
    #5 check("R9 post-write read", rd0_data, 64'h0123_4567_89AB_CDEF);

    // R8: high-byte read with new low-byte read
    @(negedge clk);
    wr_en = 1'b0;
    rd0_idx = 4'd4; rd0_size = 2'b00; rd1_idx = 4'd9; rd1_size = 2'b00;
    #5 check("R8 hi and new read", {63'h0, illegal_combo}, 64'h1);
    @(negedge clk);
    rd1_idx = 4'd1;
    #5 check("R8 hi with legacy low", {63'h0, illegal_combo}, 64'h0);
    @(negedge clk);
    rd1_idx = 4'd0; rd1_size = 2'b11;
    wr_idx = 4'd9; wr_size = 2'b00; wr_data = 64'h42;
    #5 check("R8 disabled write ignored", {63'h0, illegal_combo}, 64'h0);
    @(negedge clk);
    wr_en = 1'b1; rd0_idx = 4'd5;
    #5 check("R8 hi read with byte write", {63'h0, illegal_combo}, 64'h1);
    @(negedge clk);
    wr_en = 1'b0; rd0_idx = 4'd9; rd0_size = 2'b00;
    #5 check("R8 write still performed", rd0_data, 64'h42);
    @(negedge clk);
    ext_mode = 1'b1; rd0_idx = 4'd5; rd1_idx = 4'd9; rd1_size = 2'b00;
    #5 check("R8 ext mode no flag", {63'h0, illegal_combo}, 64'h0);

    // R1: reset in the middle of a run wins over a write
    @(negedge clk);
    ext_mode = 1'b0; rd1_idx = 4'd0; rd1_size = 2'b11;
    rst = 1'b1; wr_en = 1'b1; wr_idx = 4'd2; wr_size = 2'b11; wr_data = 64'h5555;
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    for (int r = 0; r < 16; r++) begin
      rd0_idx = 4'(r); rd0_size = 2'b11;
      #5 check($sformatf("R1 mid reset reg %0d", r), rd0_data, 64'h0);
      @(negedge clk);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule